// File: doc/BRIEF.md
# Transmit-Only LCD Serial Controller

This block is a serial master that sends bytes to an LCD panel and never receives. A host sets the command/data level, then writes a byte into a one-entry holding register. As soon as the serializer is free, the held byte and its command/data level move into a separate shift register. The holding register is then free again, so the host can queue the next byte while the current one is still going out. The byte leaves on a data pin, most significant bit first, under a clock generated from the system clock. A polarity bit picks which clock edge the panel samples on.

A two-bit size code sets the frame shape:

| Code | Frame |
|------|-------|
| 0 | Eight data bits. |
| 1 | Nine bits: the command/data level first, then the byte. |
| 2 | Eight data bits, with the command/data level held on its own pin for the whole frame. |
| 3 | Treated as code 0. |

The empty level of the holding register serves as the interrupt request. A one-cycle pulse on each move serves as the DMA request. A busy output covers the time from a write until the last queued frame has finished. An active-low framing output marks the time during which frames are on the wire.

Top module: `lcd_tx_serializer`

## Requirements
- R1: After reset, `sclk` rests at the `cfg_pol` level, `frame_n` is 1, `busy` is 0, `buf_empty` is 1, `dma_req` is 0, and `sdo` and `dcx` are 0.
- R2: A write stores `wr_data` and `wr_cmd`. From the cycle after the write, `busy` is 1 and `buf_empty` is 0.
- R3: The held byte moves to the shift register on the next clock edge when no frame is running, or else on the edge that ends the current frame. At that move, `buf_empty` goes to 1 and `dma_req` is 1 for exactly one cycle.
- R4: A write while a byte is already waiting replaces it. The replaced byte is never sent.
- R5: Size codes set the frame as follows. Codes 0 and 3 send the eight data bits MSB first, with `dcx` at 0. Code 1 sends nine bits: `wr_cmd` first, then the data MSB first. Code 2 sends eight data bits MSB first, with `dcx` equal to `wr_cmd` for the whole frame.
- R6: Each bit lasts 2*HALF_CYC clocks. For the first half of the bit, `sclk` is at the `cfg_pol` level. For the second half, it is at the opposite level. `sdo` changes only at bit boundaries, so the panel samples on the rising edge when `cfg_pol`=0 and on the falling edge when `cfg_pol`=1. Between frames, `sclk` rests at `cfg_pol`.
- R7: If a byte is waiting when a frame ends, the next frame starts on that same edge. There is no idle clock in between, and `frame_n` stays 0.
- R8: `busy` falls only on the edge that ends a frame with nothing waiting. `frame_n` is 0 exactly while frames are being sent, and `busy` is never 0 while `frame_n` is 0.
- R9: The size code and the command/data level are captured when a byte moves into the shift register. Changing `cfg_size` mid-frame does not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 2 | Frame size code (0, 3: 8 bits; 1: 9 bits with command bit first; 2: 8 bits plus command pin) |
| cfg_pol | input | 1 | Clock idle level; the panel samples on the edge that leaves it |
| wr_en | input | 1 | One-cycle write strobe into the holding register |
| wr_data | input | DATA_W | Byte to send |
| wr_cmd | input | 1 | Command/data level sent with the byte |
| sclk | output | 1 | Generated serial clock |
| sdo | output | 1 | Serial data, MSB first |
| dcx | output | 1 | Command/data pin, used with size code 2 |
| frame_n | output | 1 | Low while frames are being sent |
| busy | output | 1 | High from a write until the last queued frame ends |
| buf_empty | output | 1 | Holding register empty; serves as the interrupt request |
| dma_req | output | 1 | One-cycle pulse each time a byte moves to the shift register |

## Verification
On every cycle, the assertions check the following:
- the cycle after a write shows `busy`;
- a move only ever takes a byte that is actually held;
- a move while a frame is running happens only on the frame's last edge;
- `busy` falls only on a frame end;
- `sdo` holds within a bit;
- the DMA pulse lasts a single cycle.

The bench's scenarios show the rest:
- the bit order and the command-bit placement for each size code and both clock polarities;
- that a replaced byte is lost;
- gap-free back-to-back frames with an even edge spacing;
- the capture of the size code at load time.

// File: rtl/lcdtx_pkg.sv
package lcdtx_pkg;

  typedef enum logic [1:0] {
    SZ_PLAIN      = 2'd0,
    SZ_CMD_INLINE = 2'd1,
    SZ_CMD_PIN    = 2'd2,
    SZ_RESERVED   = 2'd3
  } size_e;

  // Number of serial bits in one frame for a size code.
  function automatic int unsigned frame_bits(input logic [1:0] code, input int unsigned dw);
    return (code == SZ_CMD_INLINE) ? dw + 1 : dw;
  endfunction

  // True when the command level is the first bit of the frame.
  function automatic logic cmd_inline(input logic [1:0] code);
    return code == SZ_CMD_INLINE;
  endfunction

  // True when the command level goes out on the separate pin.
  function automatic logic cmd_on_pin(input logic [1:0] code);
    return code == SZ_CMD_PIN;
  endfunction

endpackage

// File: rtl/lcdtx_txbuf.sv
module lcdtx_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_cmd,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_cmd
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      hold_data <= '0;
      hold_cmd  <= 1'b0;
    end else if (wr_en) begin
      full      <= 1'b1;
      hold_data <= wr_data;
      hold_cmd  <= wr_cmd;
    end else if (take) begin
      full      <= 1'b0;
    end
  end

  AST_TAKE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full); // R3
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> full); // R2
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    take && !wr_en |=> !full); // R3

endmodule

// File: rtl/lcdtx_clkgen.sv
module lcdtx_clkgen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !run)   cnt <= '0;
    else if (cnt == LAST)       cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run); // R6

endmodule

// File: rtl/lcdtx_shifter.sv
module lcdtx_shifter
  import lcdtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_cmd,
  input  logic [1:0]        ld_size,
  input  logic              pol,
  output logic              active,
  output logic              frame_end,
  output logic              sclk,
  output logic              sdo,
  output logic              dcx
);

  localparam int FW = DATA_W + 1;
  localparam int BW = $clog2(FW);

  logic [FW-1:0] sh_q;
  logic [BW-1:0] left_q;
  logic          half_q;
  logic          active_q;
  logic          pin_mode_q;
  logic          pin_cmd_q;
  logic          bit_done;

  assign bit_done  = active_q && tick && half_q;
  assign frame_end = bit_done && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      left_q     <= '0;
      half_q     <= 1'b0;
      active_q   <= 1'b0;
      pin_mode_q <= 1'b0;
      pin_cmd_q  <= 1'b0;
    end else if (load) begin
      active_q   <= 1'b1;
      half_q     <= 1'b0;
      left_q     <= BW'(frame_bits(ld_size, DATA_W) - 1);
      sh_q       <= cmd_inline(ld_size) ? {ld_cmd, ld_data} : {ld_data, 1'b0};
      pin_mode_q <= cmd_on_pin(ld_size);
      pin_cmd_q  <= ld_cmd;
    end else if (frame_end) begin
      active_q   <= 1'b0;
      half_q     <= 1'b0;
    end else if (active_q && tick) begin
      if (!half_q) begin
        half_q <= 1'b1;
      end else begin
        half_q <= 1'b0;
        left_q <= left_q - 1'b1;
        sh_q   <= {sh_q[FW-2:0], 1'b0};
      end
    end
  end

  assign active = active_q;
  assign sclk   = pol ^ (active_q & half_q);
  assign sdo    = active_q & sh_q[FW-1];
  assign dcx    = active_q & pin_mode_q & pin_cmd_q;

  AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (int'(left_q) < FW)); // R5
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !load && !bit_done |=> $stable(sdo)); // R6
  AST_LOAD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    load && active_q |-> frame_end); // R7

endmodule

// File: rtl/lcd_tx_serializer.sv
module lcd_tx_serializer #(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_pol,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_cmd,
  output logic              sclk,
  output logic              sdo,
  output logic              dcx,
  output logic              frame_n,
  output logic              busy,
  output logic              buf_empty,
  output logic              dma_req
);

  logic              full;
  logic [DATA_W-1:0] hold_data;
  logic              hold_cmd;
  logic              active;
  logic              frame_end;
  logic              tick;
  logic              load;
  logic              dma_q;

  // Move the waiting byte when the serializer is idle or finishing a frame.
  assign load = full && (!active || frame_end);

  lcdtx_txbuf #(.DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_cmd    (wr_cmd),
    .take      (load),
    .full      (full),
    .hold_data (hold_data),
    .hold_cmd  (hold_cmd)
  );

  lcdtx_clkgen #(.HALF_CYC(HALF_CYC)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (active),
    .restart (load),
    .tick    (tick)
  );

  lcdtx_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (load),
    .ld_data   (hold_data),
    .ld_cmd    (hold_cmd),
    .ld_size   (cfg_size),
    .pol       (cfg_pol),
    .active    (active),
    .frame_end (frame_end),
    .sclk      (sclk),
    .sdo       (sdo),
    .dcx       (dcx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_q <= 1'b0;
    else        dma_q <= load;
  end

  assign dma_req   = dma_q;
  assign busy      = full | active;
  assign buf_empty = ~full;
  assign frame_n   = ~active;

  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> busy); // R2
  AST_BUSY_FALL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(frame_end)); // R8
  AST_DMA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req); // R3

endmodule

// File: tb/lcd_tx_serializer_tb.sv
module lcd_tx_serializer_tb;

  localparam int DW   = 8;
  localparam int HALF = 2;
  localparam int BITP = 2 * HALF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_size = 2'd0;
  logic          cfg_pol = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_cmd = 1'b0;
  logic sclk, sdo, dcx, frame_n, busy, buf_empty, dma_req;

  lcd_tx_serializer #(.DATA_W(DW), .HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_pol(cfg_pol),
    .wr_en(wr_en), .wr_data(wr_data), .wr_cmd(wr_cmd),
    .sclk(sclk), .sdo(sdo), .dcx(dcx), .frame_n(frame_n),
    .busy(busy), .buf_empty(buf_empty), .dma_req(dma_req)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit cap_b [0:4095];
  bit cap_d [0:4095];
  bit exp_b [0:4095];
  bit exp_d [0:4095];
  int cap_n, exp_n, dma_cnt, falls, low_cyc, gap_bad, busy_bad;
  int cyc = 0;
  int last_edge = -1;
  logic prev_sclk = 1'b0;
  logic prev_fn = 1'b1;

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Monitor: capture sdo/dcx on each sampling (leading) edge of sclk.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_sclk == cfg_pol && sclk != cfg_pol) begin
        cap_b[cap_n] = sdo;
        cap_d[cap_n] = dcx;
        cap_n++;
        if (last_edge >= 0 && (cyc - last_edge) != BITP) gap_bad++;
        last_edge = cyc;
      end
      if (dma_req) dma_cnt++;
      if (!frame_n) low_cyc++;
      if (prev_fn && !frame_n) falls++;
      if (!busy && !frame_n) busy_bad++;
    end
    prev_sclk = sclk;
    prev_fn   = frame_n;
  end

  task automatic clear_log();
    cap_n = 0; exp_n = 0; dma_cnt = 0; falls = 0; low_cyc = 0;
    gap_bad = 0; busy_bad = 0; last_edge = -1;
  endtask

  task automatic push_exp(input int size, input bit cmd, input logic [DW-1:0] data);
    int n;
    int val;
    n   = (size == 1) ? DW + 1 : DW;
    val = (size == 1) ? (int'(cmd) * (1 << DW) + int'(data)) : int'(data);
    for (int i = 0; i < n; i++) begin
      exp_b[exp_n] = ((val >> (n - 1 - i)) & 1) != 0;
      exp_d[exp_n] = (size == 2) ? cmd : 1'b0;
      exp_n++;
    end
  endtask

  task automatic write_byte(input bit cmd, input logic [DW-1:0] data);
    wr_en = 1'b1; wr_data = data; wr_cmd = cmd;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input bit cmd, input logic [DW-1:0] data);
    while (!buf_empty) @(negedge clk);
    write_byte(cmd, data);
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(input string req);
    int bad;
    int first;
    bad = 0; first = -1;
    check(req, cap_n == exp_n, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      if (cap_b[i] != exp_b[i] || cap_d[i] != exp_d[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first >= 0)
      $display("  first bit %0d: sdo %0d/%0d dcx %0d/%0d", first,
               cap_b[first], exp_b[first], cap_d[first], exp_d[first]);
    check(req, bad == 0, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  logic [DW-1:0] pats [0:6];

  initial begin
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
    pats[4] = 8'h01; pats[5] = 8'h80; pats[6] = 8'h3C;
    clear_log();
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 sclk", sclk == cfg_pol, sclk, cfg_pol);
    check("R1 busy/frame", !busy && frame_n, {busy, frame_n}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 empty/dma", buf_empty && !dma_req && !sdo && !dcx,
          {buf_empty, dma_req, sdo, dcx}, 8);

    // R2, R3: write then move timing, size 0, pol 0
    clear_log();
    write_byte(1'b0, 8'hA5); push_exp(0, 1'b0, 8'hA5);
    check("R2 busy after write", busy == 1'b1, busy, 1);
    check("R2 buffer full", buf_empty == 1'b0, buf_empty, 0);
    @(negedge clk);
    check("R3 move empties", buf_empty && !frame_n, {buf_empty, frame_n}, 2);
    check("R3 dma pulse", dma_req == 1'b1, dma_req, 1);
    @(negedge clk);
    check("R3 dma one cycle", dma_req == 1'b0, dma_req, 0);
    drain();
    compare("R5 single byte");
    check("R8 frame length", low_cyc == DW * BITP, low_cyc, DW * BITP);
    check("R8 busy vs frame", busy_bad == 0 && frame_n && !busy, busy_bad, 0);

    // R5, R6, R7: sweep size codes and polarities with back-to-back streams
    for (int sz = 0; sz < 4; sz++) begin
      for (int p = 0; p < 2; p++) begin
        int nb;
        cfg_size = 2'(sz); cfg_pol = p[0];
        repeat (2) @(negedge clk);
        clear_log();
        for (int k = 0; k < 7; k++) begin
          send(k[0] ^ p[0], pats[k]);
          push_exp((sz == 3) ? 0 : sz, k[0] ^ p[0], pats[k]);
        end
        drain();
        nb = (sz == 1) ? DW + 1 : DW;
        compare($sformatf("R5 size %0d pol %0d", sz, p));
        check("R7 one gapless run", falls == 1, falls, 1);
        check("R6 edge spacing", gap_bad == 0, gap_bad, 0);
        check("R7 run length", low_cyc == 7 * nb * BITP, low_cyc, 7 * nb * BITP);
        check("R3 dma count", dma_cnt == 7, dma_cnt, 7);
        check("R6 idle level", sclk == cfg_pol, sclk, cfg_pol);
        check("R8 busy covers frames", busy_bad == 0, busy_bad, 0);
      end
    end

    // R5: exhaustive byte sweep, 9-bit frames on falling-edge sampling
    cfg_size = 2'd1; cfg_pol = 1'b1;
    repeat (2) @(negedge clk);
    clear_log();
    for (int b = 0; b < 256; b++) begin
      send(b[0] ^ b[7], 8'(b));
      push_exp(1, b[0] ^ b[7], 8'(b));
    end
    drain();
    compare("R5 exhaustive 9-bit");
    check("R3 exhaustive dma", dma_cnt == 256, dma_cnt, 256);

    // R4: overwrite of the waiting byte
    cfg_size = 2'd0; cfg_pol = 1'b0;
    repeat (2) @(negedge clk);
    clear_log();
    send(1'b0, 8'h11); push_exp(0, 1'b0, 8'h11);
    repeat (2) @(negedge clk);
    write_byte(1'b1, 8'h22);
    check("R4 waiting", buf_empty == 1'b0, buf_empty, 0);
    write_byte(1'b0, 8'h33); push_exp(0, 1'b0, 8'h33);
    drain();
    compare("R4 overwrite");
    check("R4 two moves", dma_cnt == 2, dma_cnt, 2);
    check("R7 overwrite gapless", falls == 1, falls, 1);

    // R9: size change mid-frame does not affect the frame in progress
    cfg_size = 2'd1;
    repeat (2) @(negedge clk);
    clear_log();
    send(1'b1, 8'hC3); push_exp(1, 1'b1, 8'hC3);
    repeat (3) @(negedge clk);
    cfg_size = 2'd2;
    drain();
    compare("R9 size captured");
    check("R9 frame length", low_cyc == (DW + 1) * BITP, low_cyc, (DW + 1) * BITP);

    done = 1;
    summary();
    $finish;
  end

endmodule